// File: doc/BRIEF.md
# Frame-Tagged Result Drop Filter

This block keeps the call-nesting number of one execution context and decides, for every result that comes out of a long-latency functional unit, whether that result may still be delivered. The issue logic stamps each operation with the number on `cur_nest` at the time it issues. The functional unit carries that tag through the pipeline. When the result comes out, the filter looks the tag up in a bitmap of live nesting numbers. A live tag passes the result on. A stale tag consumes the result and discards it.

Control comes in on `ctl_op`, encoded as 2'b00 idle, 2'b01 call, 2'b10 return and 2'b11 tail call. A call pushes the current number onto a return stack and moves to a fresh number. A return frees the current number and pops the saved one. A tail call frees the current number and moves to a fresh one, but leaves the stack alone, so the later return goes back to the original caller. Numbers are four bits wide and are reused after they wrap. The bitmap makes sure a freed number only matches results again once it has been handed out anew.

The result path is a valid/ready stream. A live result moves under the normal handshake: `res_in_ready` follows `res_out_ready`, so back-pressure reaches the functional unit. A dropped result never waits, because `res_in_ready` is high for it. The live check uses the live set as it stood before any control operation in the same cycle.

Top module: `frame_drop_filter`

## Requirements
- R1: After reset, `cur_nest` is 0, only number 0 is live, the return stack is empty and `ctl_stall` is 0.
- R2: A call (`ctl_op` = 2'b01) that is not stalled saves `cur_nest` on the return stack. It marks a fresh number live and makes that number current. The fresh number is the first non-live number met when searching upward from one past the last number allocated, wrapping modulo 16. At reset the last number allocated counts as 0.
- R3: A return (`ctl_op` = 2'b10) clears the current number from the live set and makes the popped number current. A return with an empty stack is ignored.
- R4: A tail call (`ctl_op` = 2'b11) that is not stalled clears the current number from the live set. It allocates a fresh number by the R2 search and leaves the return stack unchanged, so the next return restores the number saved by the last ordinary call.
- R5: `ctl_stall` is high while all 16 numbers are live or the return stack is full. While it is high, call and tail call are ignored.
- R6: A result whose `res_in_tag` is live is passed through: `res_out_valid` equals `res_in_valid`, tag and data are copied, and `res_in_ready` equals `res_out_ready`.
- R7: A result whose tag is not live is discarded: `res_out_valid` is 0 and `res_in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_op | input | 2 | Control operation: 00 idle, 01 call, 10 return, 11 tail call |
| ctl_stall | output | 1 | Call and tail call refused this cycle |
| cur_nest | output | 4 | Nesting number current for issue tagging |
| res_in_valid | input | 1 | Result from a functional unit is valid |
| res_in_ready | output | 1 | Result accepted, whether delivered or dropped |
| res_in_tag | input | 4 | Nesting number the result was issued under |
| res_in_data | input | DATA_W | Result payload |
| res_out_valid | output | 1 | Delivered result is valid |
| res_out_ready | input | 1 | Downstream accepts the delivered result |
| res_out_tag | output | 4 | Frame the delivered result belongs to |
| res_out_data | output | DATA_W | Delivered payload |

## Verification
The bench builds the block with 4-bit nesting numbers, a 16-entry return stack and 8-bit data. With 16 numbers, fifteen nested calls are enough to make every number live and raise the stall. The allocator is also driven past number 15 and back to the low numbers, so the wrapped reuse of freed numbers is exercised. At this depth the stack never fills before the numbers run out, so the stall the bench sees comes from number exhaustion.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_CALL = 2'b01,
    OP_RET  = 2'b10,
    OP_TAIL = 2'b11
  } fdf_op_e;
endpackage

// File: rtl/fdf_free_pick.sv
module fdf_free_pick #(
  parameter int W = 4,
  localparam int N = 1 << W
) (
  input  logic [N-1:0] live,
  input  logic [W-1:0] last,
  output logic         any_free,
  output logic [W-1:0] pick
);
  always_comb begin
    logic [W-1:0] idx;
    any_free = 1'b0;
    pick     = '0;
    for (int i = 0; i < N; i++) begin
      idx = last + W'(1) + W'(i);
      if (!any_free && !live[idx]) begin
        any_free = 1'b1;
        pick     = idx;
      end
    end
  end
endmodule

// File: rtl/fdf_ret_stack.sv
module fdf_ret_stack #(
  parameter int DEPTH = 16,
  parameter int W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign top   = empty ? '0 : mem[PTR_W'(cnt - CNT_W'(1))];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      mem[PTR_W'(cnt)] <= din;
      cnt <= cnt + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R5
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R3
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> empty);
endmodule

// File: rtl/fdf_result_gate.sv
module fdf_result_gate #(
  parameter int W = 4,
  parameter int DATA_W = 8,
  localparam int N = 1 << W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      live,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_tag,
  output logic [DATA_W-1:0] out_data
);
  logic tag_live;

  assign tag_live  = live[in_tag];
  assign out_valid = in_valid && tag_live;
  assign in_ready  = tag_live ? out_ready : 1'b1;
  assign out_tag   = in_tag;
  assign out_data  = in_data;

  // R7
  stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !live[in_tag]) |-> (!out_valid && in_ready));

  // R6
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);
endmodule

// File: rtl/frame_drop_filter.sv
module frame_drop_filter
  import fdf_pkg::*;
#(
  parameter int NEST_W = 4,
  parameter int RS_DEPTH = 16,
  parameter int DATA_W = 8,
  localparam int NUM_NEST = 1 << NEST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl_op,
  output logic              ctl_stall,
  output logic [NEST_W-1:0] cur_nest,
  input  logic              res_in_valid,
  output logic              res_in_ready,
  input  logic [NEST_W-1:0] res_in_tag,
  input  logic [DATA_W-1:0] res_in_data,
  output logic              res_out_valid,
  input  logic              res_out_ready,
  output logic [NEST_W-1:0] res_out_tag,
  output logic [DATA_W-1:0] res_out_data
);
  fdf_op_e             op;
  logic [NUM_NEST-1:0] live_q;
  logic [NEST_W-1:0]   cur_q, last_q;
  logic                any_free;
  logic [NEST_W-1:0]   pick;
  logic [NEST_W-1:0]   rs_top;
  logic                rs_empty, rs_full;
  logic                do_call, do_tail, do_ret;

  assign op        = fdf_op_e'(ctl_op);
  assign ctl_stall = !any_free || rs_full;
  assign do_call   = (op == OP_CALL) && !ctl_stall;
  assign do_tail   = (op == OP_TAIL) && !ctl_stall;
  assign do_ret    = (op == OP_RET) && !rs_empty;
  assign cur_nest  = cur_q;

  fdf_free_pick #(.W(NEST_W)) u_pick (
    .live(live_q), .last(last_q), .any_free(any_free), .pick(pick)
  );

  fdf_ret_stack #(.DEPTH(RS_DEPTH), .W(NEST_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(do_call), .pop(do_ret),
    .din(cur_q), .top(rs_top), .empty(rs_empty), .full(rs_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
      live_q <= NUM_NEST'(1);
    end else if (do_call) begin
      live_q[pick] <= 1'b1;
      cur_q        <= pick;
      last_q       <= pick;
    end else if (do_tail) begin
      live_q[cur_q] <= 1'b0;
      live_q[pick]  <= 1'b1;
      cur_q         <= pick;
      last_q        <= pick;
    end else if (do_ret) begin
      live_q[cur_q] <= 1'b0;
      cur_q         <= rs_top;
    end
  end

  fdf_result_gate #(.W(NEST_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .live(live_q),
    .in_valid(res_in_valid), .in_ready(res_in_ready),
    .in_tag(res_in_tag), .in_data(res_in_data),
    .out_valid(res_out_valid), .out_ready(res_out_ready),
    .out_tag(res_out_tag), .out_data(res_out_data)
  );

  // R1
  cur_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[cur_q]);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stall && ctl_op != 2'b10) |=> (cur_q == $past(cur_q)));

  // R2
  call_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_op == 2'b01 && !ctl_stall) |=> (cur_q != $past(cur_q)));

  // R4
  tail_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_op == 2'b11 && !ctl_stall) |=> !live_q[$past(cur_q)]);
endmodule

// File: tb/frame_drop_filter_tb.sv
module frame_drop_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] IDLE = 2'b00, CALL = 2'b01, RET = 2'b10, TAIL = 2'b11;
  // each entry: {op, expected cur_nest, expected ctl_stall}
  localparam logic [6:0] TBL [9] = '{
    {CALL, 4'd1, 1'b0}, {CALL, 4'd2, 1'b0}, {TAIL, 4'd3, 1'b0},
    {RET,  4'd1, 1'b0}, {CALL, 4'd4, 1'b0}, {RET,  4'd1, 1'b0},
    {RET,  4'd0, 1'b0}, {RET,  4'd0, 1'b0}, {IDLE, 4'd0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] ctl_op = IDLE;
  logic ctl_stall;
  logic [3:0] cur_nest;
  logic res_in_valid = 0, res_in_ready, res_out_valid, res_out_ready = 1;
  logic [3:0] res_in_tag = 0, res_out_tag;
  logic [7:0] res_in_data = 0, res_out_data;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] mlive;
  logic [3:0] mlast, mcur, mpick;
  logic [3:0] mstk [16];
  int msp;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_drop_filter #(.NEST_W(4), .RS_DEPTH(16), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_op(ctl_op), .ctl_stall(ctl_stall),
    .cur_nest(cur_nest), .res_in_valid(res_in_valid),
    .res_in_ready(res_in_ready), .res_in_tag(res_in_tag),
    .res_in_data(res_in_data), .res_out_valid(res_out_valid),
    .res_out_ready(res_out_ready), .res_out_tag(res_out_tag),
    .res_out_data(res_out_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [1:0] op);
    @(negedge clk); ctl_op = op;
    @(negedge clk); ctl_op = IDLE;
  endtask

  task automatic present(logic [3:0] tag, logic [7:0] data, logic ordy);
    res_in_valid = 1; res_in_tag = tag; res_in_data = data;
    res_out_ready = ordy; #1;
  endtask

  task automatic expect_deliver(string req, logic [3:0] tag, logic [7:0] data);
    present(tag, data, 1'b1);
    check(req, {31'd0, res_out_valid}, 1);
    check(req, {31'd0, res_in_ready}, 1);
    check(req, {24'd0, res_out_data}, {24'd0, data});
    check(req, {28'd0, res_out_tag}, {28'd0, tag});
    res_in_valid = 0;
  endtask

  task automatic expect_drop(string req, logic [3:0] tag);
    present(tag, 8'hEE, 1'b0);
    check(req, {31'd0, res_out_valid}, 0);
    check(req, {31'd0, res_in_ready}, 1);
    res_in_valid = 0; res_out_ready = 1;
  endtask

  task automatic model_pick();
    logic found = 0;
    for (int i = 1; i <= 16; i++) begin
      logic [3:0] idx = mlast + 4'(i);
      if (!found && !mlive[idx]) begin found = 1; mpick = idx; end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 cur", {28'd0, cur_nest}, 0);
    check("R1 stall", {31'd0, ctl_stall}, 0);
    expect_deliver("R1 frame0 live", 4'd0, 8'h11);
    expect_drop("R1 frame1 not live", 4'd1);

    // R2 R3 R4 table walk
    for (int i = 0; i < 9; i++) begin
      do_op(TBL[i][6:5]);
      check("R2/R3/R4 table cur", {28'd0, cur_nest}, {28'd0, TBL[i][4:1]});
      check("R5 table stall", {31'd0, ctl_stall}, {31'd0, TBL[i][0]});
    end

    // R6 R7 directed: last allocated is 4, current 0
    do_op(CALL);
    check("R2 call after wrap search", {28'd0, cur_nest}, 5);
    expect_deliver("R6 current frame", 4'd5, 8'hA5);
    expect_deliver("R6 caller frame still live", 4'd0, 8'h3C);
    expect_drop("R7 exited frame 4", 4'd4);
    present(4'd5, 8'h77, 1'b0);
    check("R6 backpressure ready", {31'd0, res_in_ready}, 0);
    check("R6 backpressure valid", {31'd0, res_out_valid}, 1);
    res_in_valid = 0; res_out_ready = 1;
    do_op(TAIL);
    check("R4 tail fresh number", {28'd0, cur_nest}, 6);
    expect_drop("R4 replaced frame result dropped", 4'd5);
    expect_deliver("R4 tail callee delivered", 4'd6, 8'h66);
    do_op(RET);
    check("R4 return to saved caller", {28'd0, cur_nest}, 0);
    expect_drop("R7 after return", 4'd6);

    // R5 exhaustion with wrap
    mlive = 16'h0001; mlast = 4'd6; mcur = 0; msp = 0;
    for (int i = 0; i < 15; i++) begin
      model_pick();
      mstk[msp] = mcur; msp++;
      mlive[mpick] = 1; mcur = mpick; mlast = mpick;
      do_op(CALL);
      check("R2 fill call", {28'd0, cur_nest}, {28'd0, mcur});
    end
    check("R5 stall when all live", {31'd0, ctl_stall}, 1);
    do_op(CALL);
    check("R5 call ignored", {28'd0, cur_nest}, {28'd0, mcur});
    do_op(TAIL);
    check("R5 tail ignored", {28'd0, cur_nest}, {28'd0, mcur});
    expect_deliver("R6 wrapped number live", 4'd3, 8'h5A);
    for (int i = 0; i < 15; i++) begin
      mlive[mcur] = 0; msp--; mcur = mstk[msp];
      do_op(RET);
      check("R3 unwind", {28'd0, cur_nest}, {28'd0, mcur});
      if (i == 0) check("R5 stall released", {31'd0, ctl_stall}, 0);
    end
    expect_drop("R7 all unwound", 4'd3);
    do_op(RET);
    check("R3 empty return ignored", {28'd0, cur_nest}, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule